// File: doc/BRIEF.md
# Bipolar Line Code Compliance Checker

This block is a passive hardware observer for a three-level line code. Each cycle the stream presents one symbol on three one-hot wires: negative, zero or positive. The checker tests three rules on that stream. Each rule has its own error output.

The first rule is that exactly one symbol wire is high per enabled cycle. The second rule is that the running DC sum of the stream never leaves the range -1 to +1. A positive symbol adds one to the sum and a negative symbol subtracts one. The third rule is that the stream never carries a run of `ZRUN_LIMIT` zero symbols, which is four by default.

Every error output is sticky until reset. The block only watches the stream. It does not correct or decode it. When the enable input is low, the symbol wires are ignored.

Top module: `line_code_checker`

## Requirements
- R1: After the asynchronous active-low reset, all four error outputs are 0, the running sum is 0 and the zero-run count is 0.
- R2: On an enabled cycle where the number of high wires among sym_n_i, sym_z_i and sym_p_i is 0, 2 or 3, err_excl_o is 1 from the next clock edge.
- R3: An enabled valid positive symbol that arrives while the sum is +1 sets err_hi_o from the next edge. The sum then stays at +1.
- R4: An enabled valid negative symbol that arrives while the sum is -1 sets err_lo_o from the next edge. The sum then stays at -1.
- R5: A stream whose positive and negative symbols alternate, with zeros between them, keeps the sum within -1 to +1 and raises no error.
- R6: The zero-run count grows by one on each valid zero symbol. err_zrun_o is set on the `ZRUN_LIMIT`-th consecutive valid zero. Shorter runs raise no error.
- R7: A valid positive or negative symbol clears the zero-run count.
- R8: Once set, each error output stays 1 until reset, whatever the later input.
- R9: A non-exclusive enabled cycle leaves both the sum and the zero-run count unchanged.
- R10: While en_i is 0, the symbol wires are ignored. No error is set, and neither the sum nor the zero-run count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Symbol qualifier |
| sym_n_i | input | 1 | Negative symbol |
| sym_z_i | input | 1 | Zero symbol |
| sym_p_i | input | 1 | Positive symbol |
| err_excl_o | output | 1 | Sticky: symbol wires not one-hot |
| err_hi_o | output | 1 | Sticky: sum would exceed +1 |
| err_lo_o | output | 1 | Sticky: sum would go below -1 |
| err_zrun_o | output | 1 | Sticky: zero run reached the limit |

## Verification
The bench targets the edges of the zero run.

- **Run of three, then four.** Three zeros must stay silent and the fourth must fire. A counter that is off by one fires a cycle early or a cycle late.
- **Run broken by a nonzero symbol.** A run that a positive or negative symbol interrupts must start counting again. A design that fails to clear the count flags a legal stream.

Invalid cycles are placed between meaningful symbols to test R9. A design that lets an invalid cycle move the sum or clear the count misses a later overflow that it should report.

The disabled cycles carry streams that would otherwise be violations. A checker that ignores en_i flags them.

// File: rtl/line_code_pkg.sv
package line_code_pkg;
  typedef enum logic [1:0] {
    SUM_ZERO = 2'b00,
    SUM_POS  = 2'b01,
    SUM_NEG  = 2'b10
  } dc_sum_e;
endpackage

// File: rtl/sym_onehot_check.sv
module sym_onehot_check (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sym_n_i,
  input  logic sym_z_i,
  input  logic sym_p_i,
  output logic valid_o,
  output logic err_excl_o
);
  logic [1:0] n_high;
  logic       bad;

  always_comb begin
    n_high = 2'(sym_n_i) + 2'(sym_z_i) + 2'(sym_p_i);
    bad    = en_i && (n_high != 2'd1);
    valid_o = en_i && (n_high == 2'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  err_excl_o <= 1'b0;
    else if (bad) err_excl_o <= 1'b1;
  end

  a_r2_excl_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $countones({sym_n_i, sym_z_i, sym_p_i}) != 1) |=> err_excl_o);
  a_r8_excl_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_excl_o |=> err_excl_o);
endmodule

// File: rtl/dc_sum_tracker.sv
module dc_sum_tracker
  import line_code_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sym_n_i,
  input  logic sym_p_i,
  output logic err_hi_o,
  output logic err_lo_o
);
  dc_sum_e sum_q, sum_d;
  logic    hi_hit, lo_hit;

  always_comb begin
    sum_d  = sum_q;
    hi_hit = 1'b0;
    lo_hit = 1'b0;
    if (valid_i && sym_p_i) begin
      unique case (sum_q)
        SUM_NEG:  sum_d = SUM_ZERO;
        SUM_ZERO: sum_d = SUM_POS;
        default:  hi_hit = 1'b1; // saturate at +1
      endcase
    end else if (valid_i && sym_n_i) begin
      unique case (sum_q)
        SUM_POS:  sum_d = SUM_ZERO;
        SUM_ZERO: sum_d = SUM_NEG;
        default:  lo_hit = 1'b1; // saturate at -1
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q    <= SUM_ZERO;
      err_hi_o <= 1'b0;
      err_lo_o <= 1'b0;
    end else begin
      sum_q <= sum_d;
      if (hi_hit) err_hi_o <= 1'b1;
      if (lo_hit) err_lo_o <= 1'b1;
    end
  end

  a_r3_hi_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sym_p_i && sum_q == SUM_POS) |=> (err_hi_o && sum_q == SUM_POS));
  a_r4_lo_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sym_n_i && sum_q == SUM_NEG) |=> (err_lo_o && sum_q == SUM_NEG));
  a_r9_sum_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sum_q));
  a_r8_dc_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_hi_o || err_lo_o) |=> (err_hi_o || err_lo_o));
endmodule

// File: rtl/zero_run_counter.sv
module zero_run_counter #(
  parameter int unsigned ZRUN_LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sym_z_i,
  output logic err_zrun_o
);
  localparam int unsigned CW = (ZRUN_LIMIT > 2) ? $clog2(ZRUN_LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(ZRUN_LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      err_zrun_o <= 1'b0;
    end else if (valid_i) begin
      if (!sym_z_i)           cnt_q <= '0;
      else if (cnt_q == LAST) err_zrun_o <= 1'b1;
      else                    cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r6_zrun_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sym_z_i && cnt_q == LAST) |=> err_zrun_o);
  a_r7_zrun_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sym_z_i) |=> (cnt_q == '0));
  a_r9_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_q));
  a_r8_zrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_zrun_o |=> err_zrun_o);
endmodule

// File: rtl/line_code_checker.sv
module line_code_checker #(
  parameter int unsigned ZRUN_LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sym_n_i,
  input  logic sym_z_i,
  input  logic sym_p_i,
  output logic err_excl_o,
  output logic err_hi_o,
  output logic err_lo_o,
  output logic err_zrun_o
);
  logic sym_valid;

  sym_onehot_check u_onehot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .sym_n_i    (sym_n_i),
    .sym_z_i    (sym_z_i),
    .sym_p_i    (sym_p_i),
    .valid_o    (sym_valid),
    .err_excl_o (err_excl_o)
  );

  dc_sum_tracker u_sum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (sym_valid),
    .sym_n_i  (sym_n_i),
    .sym_p_i  (sym_p_i),
    .err_hi_o (err_hi_o),
    .err_lo_o (err_lo_o)
  );

  zero_run_counter #(.ZRUN_LIMIT(ZRUN_LIMIT)) u_zrun (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (sym_valid),
    .sym_z_i    (sym_z_i),
    .err_zrun_o (err_zrun_o)
  );

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !err_excl_o && !err_hi_o && !err_lo_o && !err_zrun_o)
      |=> !(err_excl_o || err_hi_o || err_lo_o || err_zrun_o));
endmodule

// File: tb/line_code_checker_tb.sv
module line_code_checker_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, sym_n_i = 1'b0, sym_z_i = 1'b0, sym_p_i = 1'b0;
  logic err_excl_o, err_hi_o, err_lo_o, err_zrun_o;
  int   n_chk = 0, n_err = 0;

  always #2 clk = ~clk; // 250 MHz

  line_code_checker u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i),
    .sym_n_i(sym_n_i), .sym_z_i(sym_z_i), .sym_p_i(sym_p_i),
    .err_excl_o(err_excl_o), .err_hi_o(err_hi_o),
    .err_lo_o(err_lo_o), .err_zrun_o(err_zrun_o)
  );

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: flags{excl,hi,lo,zrun} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] flags();
    return {err_excl_o, err_hi_o, err_lo_o, err_zrun_o};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    en_i = 0; sym_n_i = 0; sym_z_i = 0; sym_p_i = 0;
    rst_ni = 0;
    @(negedge clk);
    rst_ni = 1;
  endtask

  // drive one symbol at negedge; the following negedge is after the capture edge
  task automatic send(logic e, logic n, logic z, logic p);
    en_i = e; sym_n_i = n; sym_z_i = z; sym_p_i = p;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset", flags(), 4'b0000);
  endtask

  task automatic t_excl();
    do_reset(); send(1,0,0,0); chk("R2 none high", flags(), 4'b1000);
    do_reset(); send(1,1,0,1); chk("R2 two high", flags(), 4'b1000);
    do_reset(); send(1,1,1,1); chk("R2 three high", flags(), 4'b1000);
    send(1,0,1,0); send(1,0,0,1);
    chk("R8 excl sticky", flags(), 4'b1000);
  endtask

  task automatic t_clean();
    do_reset();
    send(1,0,0,1); send(1,0,1,0); send(1,1,0,0); send(1,1,0,0);
    send(1,0,1,0); send(1,0,0,1); send(1,0,0,1); send(1,0,1,0);
    send(1,0,1,0); send(1,0,1,0); send(1,1,0,0);
    chk("R5 alternating clean", flags(), 4'b0000);
  endtask

  task automatic t_dc();
    do_reset(); send(1,0,0,1); chk("R3 first p ok", flags(), 4'b0000);
    send(1,0,0,1); chk("R3 second p", flags(), 4'b0100);
    send(1,1,0,0); send(1,1,0,0); chk("R3 sum held at +1", flags(), 4'b0100);
    do_reset(); send(1,1,0,0); send(1,1,0,0); chk("R4 second n", flags(), 4'b0010);
    send(1,0,0,1); send(1,0,0,1); chk("R8 lo sticky / R4 held at -1", flags(), 4'b0010);
  endtask

  task automatic t_zrun();
    do_reset(); send(1,0,1,0); send(1,0,1,0); send(1,0,1,0);
    chk("R6 three z quiet", flags(), 4'b0000);
    send(1,0,1,0); chk("R6 fourth z", flags(), 4'b0001);
    send(1,0,0,1); send(1,1,0,0); chk("R8 zrun sticky", flags(), 4'b0001);
    do_reset(); send(1,0,1,0); send(1,0,1,0); send(1,0,1,0); send(1,0,0,1);
    send(1,0,1,0); send(1,0,1,0); send(1,0,1,0);
    chk("R7 p clears run", flags(), 4'b0000);
    send(1,1,0,0); send(1,0,1,0); send(1,0,1,0); send(1,0,1,0);
    chk("R7 n clears run", flags(), 4'b0000);
  endtask

  task automatic t_invalid_hold();
    do_reset(); send(1,0,0,1); send(1,1,0,1); send(1,0,0,1);
    chk("R9 sum kept over invalid", flags(), 4'b1100);
    do_reset(); send(1,0,1,0); send(1,0,1,0); send(1,0,1,0);
    send(1,0,1,1); send(1,0,1,0);
    chk("R9 count kept over invalid", flags(), 4'b1001);
  endtask

  task automatic t_disable();
    do_reset();
    send(0,1,1,1); send(0,0,0,0); send(0,0,0,1); send(0,0,0,1);
    send(0,0,1,0); send(0,0,1,0); send(0,0,1,0); send(0,0,1,0);
    chk("R10 disabled quiet", flags(), 4'b0000);
    send(1,0,0,1); chk("R10 sum unchanged", flags(), 4'b0000);
    send(0,0,0,1); send(1,1,0,0); send(1,1,0,0);
    chk("R10 ignored p", flags(), 4'b0000);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_excl(); t_clean(); t_dc();
        t_zrun(); t_invalid_hold(); t_disable();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule